// File: doc/BRIEF.md
# CPU Packet Endpoint Register Interface

This block sits between a processor bus and a word-stream network port. Software sees seven 16-bit registers. It builds an outgoing packet by writing words one at a time into a transmit buffer and then starts the send with a flush bit. Incoming packets arrive on a 16-bit stream with start and end markers. Each packet is checked against its own header and then stored in a receive buffer, which software drains one word per read. A status word shows the state of the word at the head of that buffer, so software can see packet boundaries while it reads.

Every packet begins with a four-word header: destination address, source address, a word that carries the packet type in bits 15:8 and a block counter in bits 7:0, and the payload length in bytes. The block counter is inserted by hardware on transmit and checked for progression on receive. Error and timeout conditions are kept as sticky status flags, and software clears them by writing the status value back. An interrupt output is formed from two live conditions and two latched events, each gated by its own enable bit.

Top module: `pkt_ep_regs`

## Requirements
- R1: After reset the status, control, interrupt and address registers all read 0. The irq output and the net_tx_valid output are 0.
- R2: Register offsets: 0 transmit data, 1 control, 2 receive data, 3 status, 4 own address, 5 peer address, 6 interrupt. Each write to offset 0 appends one word. Writing control with bit 15 set sends the held words in order on the network port, with sop on the first word and eop on the last. A word stays on the port until net_tx_ready accepts it. While words are held and no send is running, status bit 0 reads 1. While a send runs, status bit 1 reads 1.
- R3: On transmit, bits 7:0 of the third word are replaced by a hardware packet counter, and bits 15:8 are kept. The counter is 0 after reset and increases by one for each packet sent.
- R4: Status bit 2 reads 1 when the transmit buffer holds TX_DEPTH words. A write to offset 0 while the buffer is full, or while a send runs, is dropped and sets status bit 3. A flush with an empty buffer sends nothing.
- R5: Control bit 12 enables reception and reads back at bit 12. A packet whose first word arrives while this bit is 0 is not stored, and no flag is set.
- R6: Each read of offset 2 returns the head word and removes it. Status bit 15 means data is available. Bit 13 marks the head as the first word of a packet and bit 12 marks it as the last. With no data, the read returns 0, removes nothing, and bits 15, 13 and 12 read 0.
- R7: A received packet is stored only if its total word count equals 4 + ceil(L/2), where L is the fourth word. Otherwise the packet is discarded and status bit 8 is set.
- R8: A packet that does not fit in the free receive space is discarded whole and sets status bit 11. Packets stored before it are not affected.
- R9: Take d as the counter of a stored packet (bits 7:0 of its third word) minus the counter of the previous stored packet, mod 256. If d is 0 or at least 128, status bit 9 is set. The packet is still stored.
- R10: One-cycle pulses on the fault inputs set status bits: receive timeout bit 4, store timeout bit 5, read timeout bit 6, distribution error bit 7, checksum error bit 10.
- R11: Status bits 3 to 11 stay set until software writes 1 to them at offset 3. Bits written 0 are unchanged. If a set and a clear land in the same cycle, the set wins. Bit 14 reads 0.
- R12: Interrupt register bits 8:5 are the enables for: transmit buffer free (empty and idle), packet sent, packet stored, and receive data available. Bit 9 latches a packet-sent event and bit 10 latches a packet-stored event; writing 1 to either bit clears it. irq is the OR of the enabled conditions.
- R13: The own and peer address registers read back what was written and drive own_addr and peer_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the receive buffer at offset 2) |
| bus_addr | input | 3 | Register word offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| net_tx_valid | output | 1 | Outgoing word valid |
| net_tx_ready | input | 1 | Network accepts the outgoing word |
| net_tx_data | output | 16 | Outgoing word |
| net_tx_sop | output | 1 | First word of the outgoing packet |
| net_tx_eop | output | 1 | Last word of the outgoing packet |
| net_rx_valid | input | 1 | Incoming word valid |
| net_rx_data | input | 16 | Incoming word |
| net_rx_sop | input | 1 | First word of the incoming packet |
| net_rx_eop | input | 1 | Last word of the incoming packet |
| flt_rx_timeout | input | 1 | Receive timeout pulse |
| flt_store_timeout | input | 1 | Store timeout pulse |
| flt_read_timeout | input | 1 | Read timeout pulse |
| flt_dist | input | 1 | Distribution error pulse |
| flt_fcs | input | 1 | Checksum error pulse |
| own_addr | output | 16 | Own address register |
| peer_addr | output | 16 | Peer address register |
| irq | output | 1 | Interrupt request |

## Verification
Any bad transmit pointer or word index appears on the network port at the first accepted word: a word is out of order, carries the wrong counter byte, or has a misplaced sop or eop. The bench compares the port against a queue of expected words on every clock. A bad receive commit or rollback shows up in the status word within three cycles of the end of a packet. It also shows up in the data returned by the following reads. A bad sticky flag or pending bit shows up on the next read of the status or interrupt register, or on irq right away.

// File: rtl/pkt_ep_pkg.sv
package pkt_ep_pkg;
   localparam int unsigned WORD_W = 16;

   localparam logic [2:0] ADR_TXDATA = 3'd0;
   localparam logic [2:0] ADR_CTRL   = 3'd1;
   localparam logic [2:0] ADR_RXDATA = 3'd2;
   localparam logic [2:0] ADR_STATUS = 3'd3;
   localparam logic [2:0] ADR_OWN    = 3'd4;
   localparam logic [2:0] ADR_PEER   = 3'd5;
   localparam logic [2:0] ADR_IRQ    = 3'd6;

   localparam int CTL_RXEN  = 12;
   localparam int CTL_FLUSH = 15;

   localparam int ST_BUILD   = 0;
   localparam int ST_SEND    = 1;
   localparam int ST_FULL    = 2;
   localparam int ST_TXERR   = 3;
   localparam int ST_RXTMO   = 4;
   localparam int ST_STTMO   = 5;
   localparam int ST_RDTMO   = 6;
   localparam int ST_DIST    = 7;
   localparam int ST_LEN     = 8;
   localparam int ST_FCNT    = 9;
   localparam int ST_FCS     = 10;
   localparam int ST_DROP    = 11;
   localparam int ST_LAST    = 12;
   localparam int ST_FIRST   = 13;
   localparam int ST_AVAIL   = 15;

   localparam logic [15:0] STICKY_MASK = 16'h0FF8;

   localparam int IE_LO     = 5;
   localparam int IE_HI     = 8;
   localparam int IP_TXDONE = 9;
   localparam int IP_RXPKT  = 10;

   typedef struct packed {
      logic              first;
      logic              last;
      logic [WORD_W-1:0] data;
   } ep_word_t;
endpackage

// File: rtl/ep_tx_path.sv
module ep_tx_path
   import pkt_ep_pkg::*;
#(
   parameter int unsigned DEPTH = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [WORD_W-1:0] push_data,
   input  logic              flush,
   output logic              building,
   output logic              sending,
   output logic              full,
   output logic              idle_empty,
   output logic              push_err,
   output logic              done,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [WORD_W-1:0] out_data,
   output logic              out_sop,
   output logic              out_eop
);
   localparam int unsigned AW = $clog2(DEPTH);
   localparam logic [AW:0] DEPTH_P = (AW+1)'(DEPTH);

   logic [WORD_W-1:0] mem [DEPTH];
   logic [AW:0]       wr_q, rd_q;
   logic              send_q;
   logic [1:0]        idx_q;
   logic [7:0]        pkt_ctr_q;
   logic              err_q, done_q;

   logic empty, push_ok, start, xfer, at_last;
   logic [WORD_W-1:0] head;

   assign empty   = (wr_q == rd_q);
   assign full    = ((wr_q - rd_q) == DEPTH_P);
   assign push_ok = push && !full && !send_q;
   assign start   = flush && !send_q && !empty;
   assign xfer    = send_q && out_ready;
   assign at_last = ((rd_q + 1'b1) == wr_q);
   assign head    = mem[rd_q[AW-1:0]];

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_q[AW-1:0]] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q      <= '0;
         rd_q      <= '0;
         send_q    <= 1'b0;
         idx_q     <= '0;
         pkt_ctr_q <= '0;
         err_q     <= 1'b0;
         done_q    <= 1'b0;
      end else begin
         err_q  <= push && !push_ok;
         done_q <= 1'b0;
         if (push_ok) wr_q <= wr_q + 1'b1;
         if (start) begin
            send_q <= 1'b1;
            idx_q  <= '0;
         end
         if (xfer) begin
            rd_q <= rd_q + 1'b1;
            if (idx_q != 2'd3) idx_q <= idx_q + 1'b1;
            if (at_last) begin
               send_q    <= 1'b0;
               done_q    <= 1'b1;
               pkt_ctr_q <= pkt_ctr_q + 8'd1;
            end
         end
      end
   end

   always_comb begin
      out_data = '0;
      if (send_q) begin
         out_data = head;
         if (idx_q == 2'd2) out_data[7:0] = pkt_ctr_q;
      end
   end

   assign out_valid  = send_q;
   assign out_sop    = send_q && (idx_q == 2'd0);
   assign out_eop    = send_q && at_last;
   assign building   = !empty && !send_q;
   assign sending    = send_q;
   assign idle_empty = empty && !send_q;
   assign push_err   = err_q;
   assign done       = done_q;
endmodule

// File: rtl/ep_rx_path.sv
module ep_rx_path
   import pkt_ep_pkg::*;
#(
   parameter int unsigned DEPTH = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] in_data,
   input  logic              in_sop,
   input  logic              in_eop,
   input  logic              pop,
   output logic [WORD_W-1:0] head_data,
   output logic              head_first,
   output logic              head_last,
   output logic              avail,
   output logic              ev_pkt,
   output logic              err_len,
   output logic              err_drop,
   output logic              err_fc
);
   localparam int unsigned AW = $clog2(DEPTH);
   localparam logic [AW:0] DEPTH_P = (AW+1)'(DEPTH);

   ep_word_t    mem [DEPTH];
   logic [AW:0] wr_q, cm_q, rd_q;
   logic        acc_q, ovf_q, have_prev_q;
   logic [15:0] cnt_q, len_q;
   logic [7:0]  bc_q, prev_bc_q;
   logic        ev_q, len_err_q, drop_q, fc_q;

   logic        take, room, ovf_now, do_write, fin, good, inc_ok;
   logic [AW:0] wbase;
   logic [15:0] cnt_now, len_now;
   logic [7:0]  bc_now, bc_diff;
   logic [16:0] total, need;
   ep_word_t    head;

   assign take     = in_valid && (in_sop ? en : acc_q);
   assign wbase    = in_sop ? cm_q : wr_q;
   assign room     = ((wbase - rd_q) != DEPTH_P);
   assign ovf_now  = in_sop ? !room : (ovf_q || !room);
   assign do_write = take && !ovf_now;
   assign cnt_now  = in_sop ? 16'd0 : cnt_q;
   assign len_now  = (cnt_now == 16'd3) ? in_data : len_q;
   assign bc_now   = (cnt_now == 16'd2) ? in_data[7:0] : bc_q;
   assign total    = {1'b0, cnt_now} + 17'd1;
   assign need     = 17'd4 + (({1'b0, len_now} + 17'd1) >> 1);
   assign fin      = take && in_eop;
   assign good     = fin && !ovf_now && (total == need);
   assign bc_diff  = bc_now - prev_bc_q;
   assign inc_ok   = (bc_diff != 8'd0) && !bc_diff[7];
   assign avail    = (cm_q != rd_q);
   assign head     = mem[rd_q[AW-1:0]];

   always_ff @(posedge clk) begin
      if (do_write) mem[wbase[AW-1:0]] <= '{first: in_sop, last: in_eop, data: in_data};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q        <= '0;
         cm_q        <= '0;
         rd_q        <= '0;
         acc_q       <= 1'b0;
         ovf_q       <= 1'b0;
         have_prev_q <= 1'b0;
         cnt_q       <= '0;
         len_q       <= '0;
         bc_q        <= '0;
         prev_bc_q   <= '0;
         ev_q        <= 1'b0;
         len_err_q   <= 1'b0;
         drop_q      <= 1'b0;
         fc_q        <= 1'b0;
      end else begin
         ev_q      <= good;
         len_err_q <= fin && !ovf_now && (total != need);
         drop_q    <= fin && ovf_now;
         fc_q      <= good && have_prev_q && !inc_ok;
         if (in_valid && in_sop && !en) begin
            acc_q <= 1'b0;
            wr_q  <= cm_q;
         end
         if (take) begin
            acc_q <= !in_eop;
            ovf_q <= ovf_now;
            cnt_q <= (cnt_now == 16'hFFFF) ? cnt_now : cnt_now + 16'd1;
            len_q <= len_now;
            bc_q  <= bc_now;
            wr_q  <= do_write ? wbase + 1'b1 : wbase;
            if (fin) begin
               if (good) begin
                  cm_q        <= wbase + 1'b1;
                  have_prev_q <= 1'b1;
                  prev_bc_q   <= bc_now;
               end else begin
                  wr_q <= cm_q;
               end
            end
         end
         if (pop && avail) rd_q <= rd_q + 1'b1;
      end
   end

   assign head_data  = avail ? head.data : '0;
   assign head_first = avail && head.first;
   assign head_last  = avail && head.last;
   assign ev_pkt     = ev_q;
   assign err_len    = len_err_q;
   assign err_drop   = drop_q;
   assign err_fc     = fc_q;
endmodule

// File: rtl/ep_status_irq.sv
module ep_status_irq
   import pkt_ep_pkg::*;
#(
   parameter logic [15:0] MASK    = STICKY_MASK,
   parameter bit          REG_OUT = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [15:0] set_vec,
   input  logic [15:0] clr_vec,
   input  logic        ie_wr,
   input  logic [15:0] ie_wdata,
   input  logic        ev_txdone,
   input  logic        ev_rxpkt,
   input  logic        live_txfree,
   input  logic        live_rxavail,
   output logic [15:0] sticky,
   output logic [3:0]  ie_q,
   output logic        pend_tx,
   output logic        pend_rx,
   output logic        irq
);
   for (genvar i = 0; i < 16; i++) begin : g_flag
      if (MASK[i]) begin : g_ff
         logic b_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          b_q <= 1'b0;
            else if (set_vec[i]) b_q <= 1'b1;
            else if (clr_vec[i]) b_q <= 1'b0;
         end
         assign sticky[i] = b_q;
      end else begin : g_tie
         assign sticky[i] = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ie_q    <= '0;
         pend_tx <= 1'b0;
         pend_rx <= 1'b0;
      end else begin
         if (ie_wr) ie_q <= ie_wdata[IE_HI:IE_LO];
         pend_tx <= ev_txdone || (pend_tx && !(ie_wr && ie_wdata[IP_TXDONE]));
         pend_rx <= ev_rxpkt  || (pend_rx && !(ie_wr && ie_wdata[IP_RXPKT]));
      end
   end

   logic irq_c;
   assign irq_c = |(ie_q & {live_rxavail, pend_rx, pend_tx, live_txfree});

   if (REG_OUT) begin : g_irq_ff
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= irq_c;
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = irq_c;
   end
endmodule

// File: rtl/pkt_ep_regs.sv
module pkt_ep_regs
   import pkt_ep_pkg::*;
#(
   parameter int unsigned TX_DEPTH       = 16,
   parameter int unsigned RX_DEPTH       = 32,
   parameter bit          IRQ_REGISTERED = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_wr,
   input  logic        bus_rd,
   input  logic [2:0]  bus_addr,
   input  logic [15:0] bus_wdata,
   output logic [15:0] bus_rdata,
   output logic        net_tx_valid,
   input  logic        net_tx_ready,
   output logic [15:0] net_tx_data,
   output logic        net_tx_sop,
   output logic        net_tx_eop,
   input  logic        net_rx_valid,
   input  logic [15:0] net_rx_data,
   input  logic        net_rx_sop,
   input  logic        net_rx_eop,
   input  logic        flt_rx_timeout,
   input  logic        flt_store_timeout,
   input  logic        flt_read_timeout,
   input  logic        flt_dist,
   input  logic        flt_fcs,
   output logic [15:0] own_addr,
   output logic [15:0] peer_addr,
   output logic        irq
);
   if (TX_DEPTH < 2 || (TX_DEPTH & (TX_DEPTH - 1)) != 0) begin : g_bad_tx
      $error("TX_DEPTH must be a power of two of at least 2");
   end
   if (RX_DEPTH < 8 || (RX_DEPTH & (RX_DEPTH - 1)) != 0) begin : g_bad_rx
      $error("RX_DEPTH must be a power of two of at least 8");
   end

   logic wr_txd, wr_ctl, wr_st, wr_own, wr_peer, wr_ie, rd_rxd;
   assign wr_txd  = bus_wr && (bus_addr == ADR_TXDATA);
   assign wr_ctl  = bus_wr && (bus_addr == ADR_CTRL);
   assign wr_st   = bus_wr && (bus_addr == ADR_STATUS);
   assign wr_own  = bus_wr && (bus_addr == ADR_OWN);
   assign wr_peer = bus_wr && (bus_addr == ADR_PEER);
   assign wr_ie   = bus_wr && (bus_addr == ADR_IRQ);
   assign rd_rxd  = bus_rd && (bus_addr == ADR_RXDATA);

   logic        rx_en_q;
   logic [15:0] own_q, peer_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_en_q <= 1'b0;
         own_q   <= '0;
         peer_q  <= '0;
      end else begin
         if (wr_ctl)  rx_en_q <= bus_wdata[CTL_RXEN];
         if (wr_own)  own_q   <= bus_wdata;
         if (wr_peer) peer_q  <= bus_wdata;
      end
   end

   logic tx_building, tx_sending, tx_full, tx_free, tx_err, tx_done;

   ep_tx_path #(.DEPTH(TX_DEPTH)) i_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (wr_txd),
      .push_data (bus_wdata),
      .flush     (wr_ctl && bus_wdata[CTL_FLUSH]),
      .building  (tx_building),
      .sending   (tx_sending),
      .full      (tx_full),
      .idle_empty(tx_free),
      .push_err  (tx_err),
      .done      (tx_done),
      .out_valid (net_tx_valid),
      .out_ready (net_tx_ready),
      .out_data  (net_tx_data),
      .out_sop   (net_tx_sop),
      .out_eop   (net_tx_eop)
   );

   logic [15:0] rx_head;
   logic        rx_first, rx_last, rx_avail, rx_ev, rx_len_err, rx_drop, rx_fc;

   ep_rx_path #(.DEPTH(RX_DEPTH)) i_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (rx_en_q),
      .in_valid  (net_rx_valid),
      .in_data   (net_rx_data),
      .in_sop    (net_rx_sop),
      .in_eop    (net_rx_eop),
      .pop       (rd_rxd),
      .head_data (rx_head),
      .head_first(rx_first),
      .head_last (rx_last),
      .avail     (rx_avail),
      .ev_pkt    (rx_ev),
      .err_len   (rx_len_err),
      .err_drop  (rx_drop),
      .err_fc    (rx_fc)
   );

   logic [15:0] set_vec, sticky;
   logic [3:0]  ie_q;
   logic        pend_tx, pend_rx;

   always_comb begin
      set_vec           = '0;
      set_vec[ST_TXERR] = tx_err;
      set_vec[ST_RXTMO] = flt_rx_timeout;
      set_vec[ST_STTMO] = flt_store_timeout;
      set_vec[ST_RDTMO] = flt_read_timeout;
      set_vec[ST_DIST]  = flt_dist;
      set_vec[ST_LEN]   = rx_len_err;
      set_vec[ST_FCNT]  = rx_fc;
      set_vec[ST_FCS]   = flt_fcs;
      set_vec[ST_DROP]  = rx_drop;
   end

   ep_status_irq #(.MASK(STICKY_MASK), .REG_OUT(IRQ_REGISTERED)) i_stat (
      .clk         (clk),
      .rst_n       (rst_n),
      .set_vec     (set_vec),
      .clr_vec     (wr_st ? bus_wdata : 16'h0000),
      .ie_wr       (wr_ie),
      .ie_wdata    (bus_wdata),
      .ev_txdone   (tx_done),
      .ev_rxpkt    (rx_ev),
      .live_txfree (tx_free),
      .live_rxavail(rx_avail),
      .sticky      (sticky),
      .ie_q        (ie_q),
      .pend_tx     (pend_tx),
      .pend_rx     (pend_rx),
      .irq         (irq)
   );

   logic [15:0] stat_view;
   always_comb begin
      stat_view           = sticky & STICKY_MASK;
      stat_view[ST_BUILD] = tx_building;
      stat_view[ST_SEND]  = tx_sending;
      stat_view[ST_FULL]  = tx_full;
      stat_view[ST_LAST]  = rx_last;
      stat_view[ST_FIRST] = rx_first;
      stat_view[ST_AVAIL] = rx_avail;
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADR_CTRL:   bus_rdata[CTL_RXEN] = rx_en_q;
         ADR_RXDATA: bus_rdata = rx_head;
         ADR_STATUS: bus_rdata = stat_view;
         ADR_OWN:    bus_rdata = own_q;
         ADR_PEER:   bus_rdata = peer_q;
         ADR_IRQ:    bus_rdata = {5'b0, pend_rx, pend_tx, ie_q, 5'b0};
         default:    bus_rdata = '0;
      endcase
   end

   assign own_addr  = own_q;
   assign peer_addr = peer_q;
endmodule

// File: rtl/ep_checker.sv
module ep_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        bus_wr,
   input logic        bus_rd,
   input logic [2:0]  bus_addr,
   input logic [15:0] bus_wdata,
   input logic [15:0] bus_rdata,
   input logic        net_tx_valid,
   input logic        net_tx_ready,
   input logic [15:0] net_tx_data,
   input logic        net_tx_sop,
   input logic        net_tx_eop,
   input logic        irq,
   input logic [15:0] stat_view,
   input logic [3:0]  ie_q
);
   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      net_tx_valid && !net_tx_ready |=> net_tx_valid && $stable(net_tx_data)
                                        && $stable(net_tx_sop) && $stable(net_tx_eop));

   p_eop_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
      net_tx_valid && net_tx_ready && net_tx_eop |=> !net_tx_valid);

   p_drop_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && bus_addr == 3'd0 && (stat_view[2] || stat_view[1]) |=> ##1 stat_view[3]);

   p_empty_rd_r6: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd && bus_addr == 3'd2 && !stat_view[15] |-> bus_rdata == 16'h0000);

   p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && bus_addr == 3'd3 && bus_wdata[3] && !$past(bus_wr && bus_addr == 3'd0)
      |=> !stat_view[3]);

   p_rsvd_r11: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd && bus_addr == 3'd3 |-> !bus_rdata[14]);

   p_irq_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
      ie_q == 4'd0 && $past(ie_q) == 4'd0 |-> !irq);
endmodule

bind pkt_ep_regs ep_checker i_chk (.*);

// File: tb/test_pkt_ep_regs.sv
module test_pkt_ep_regs;
   typedef logic [15:0] wq_t[$];

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [2:0]  bus_addr = 3'd0;
   logic [15:0] bus_wdata = '0, bus_rdata;
   logic        net_tx_valid, net_tx_ready = 1'b1, net_tx_sop, net_tx_eop;
   logic [15:0] net_tx_data;
   logic        net_rx_valid = 1'b0, net_rx_sop = 1'b0, net_rx_eop = 1'b0;
   logic [15:0] net_rx_data = '0;
   logic        flt_rx_timeout = 0, flt_store_timeout = 0, flt_read_timeout = 0, flt_dist = 0, flt_fcs = 0;
   logic [15:0] own_addr, peer_addr;
   logic        irq;

   always #4 clk = ~clk;

   pkt_ep_regs i_pkt_ep_regs (.*);

   int n_chk = 0, n_fail = 0;
   bit finished = 0;
   logic [17:0] exp_tx[$];

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // stream reference: every accepted word is compared with the model queue
   always @(negedge clk) begin
      if (rst_n && net_tx_valid && net_tx_ready) begin
         if (exp_tx.size() == 0) begin
            n_chk++; n_fail++;
            $display("FAIL R2 R4: actual word %h sent, expected none", net_tx_data);
         end else begin
            logic [17:0] e;
            e = exp_tx.pop_front();
            chk("R2 R3 tx stream", {14'b0, net_tx_sop, net_tx_eop, net_tx_data}, {14'b0, e});
         end
      end
   end

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] d);
      bus_addr = a; bus_rd = 1'b1;
      #2 d = bus_rdata;
      @(posedge clk); #1;
      bus_rd = 1'b0;
   endtask

   task automatic chk_reg(input string req, input logic [2:0] a, input logic [15:0] exp);
      logic [15:0] d;
      rd(a, d);
      chk(req, {16'b0, d}, {16'b0, exp});
   endtask

   task automatic tx_expect(input wq_t w, input logic [7:0] ctr);
      foreach (w[i]) begin
         logic [15:0] v;
         v = w[i];
         if (i == 2) v[7:0] = ctr;
         exp_tx.push_back({i == 0, i == w.size() - 1, v});
      end
   endtask

   task automatic tx_drain(input bit toggle);
      for (int k = 0; k < 400; k++) begin
         if (exp_tx.size() == 0 && !net_tx_valid) break;
         net_tx_ready = toggle ? ~net_tx_ready : 1'b1;
         @(posedge clk); #1;
      end
      net_tx_ready = 1'b1;
      chk("R2 all words sent", exp_tx.size(), 0);
   endtask

   function automatic wq_t mkpkt(input logic [7:0] bc, input logic [15:0] len,
                                 input int npay, input logic [15:0] base);
      wq_t q;
      q.push_back(16'h00A1);
      q.push_back(16'h00B2);
      q.push_back({8'h07, bc});
      q.push_back(len);
      for (int i = 0; i < npay; i++) q.push_back(base + 16'(i));
      return q;
   endfunction

   task automatic rx_send(input wq_t w);
      foreach (w[i]) begin
         net_rx_valid = 1'b1; net_rx_data = w[i];
         net_rx_sop = (i == 0); net_rx_eop = (i == w.size() - 1);
         @(posedge clk); #1;
      end
      net_rx_valid = 1'b0; net_rx_sop = 1'b0; net_rx_eop = 1'b0;
   endtask

   task automatic rx_drain(input string req, input wq_t w);
      foreach (w[i]) begin
         logic [15:0] d;
         rd(3'd2, d);
         chk(req, {16'b0, d}, {16'b0, w[i]});
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      wq_t p, q;
      idle(3);
      rst_n = 1'b1;
      idle(2);

      // R1 reset state
      chk_reg("R1 status", 3'd3, 16'h0000);
      chk_reg("R1 control", 3'd1, 16'h0000);
      chk_reg("R1 irq reg", 3'd6, 16'h0000);
      chk_reg("R1 own", 3'd4, 16'h0000);
      chk("R1 irq pin", irq, 0);
      chk("R1 tx valid", net_tx_valid, 0);

      // R13 address registers
      wr(3'd4, 16'h1234);
      wr(3'd5, 16'hBEEF);
      chk_reg("R13 own readback", 3'd4, 16'h1234);
      chk_reg("R13 peer readback", 3'd5, 16'hBEEF);
      chk("R13 own pin", own_addr, 16'h1234);
      chk("R13 peer pin", peer_addr, 16'hBEEF);

      // R2 R3 first packet, counter 0
      p = '{16'h1111, 16'h2222, 16'h33CC, 16'h0004, 16'h5555};
      net_tx_ready = 1'b0;
      foreach (p[i]) wr(3'd0, p[i]);
      chk_reg("R2 building", 3'd3, 16'h0001);
      tx_expect(p, 8'h00);
      wr(3'd1, 16'h8000);
      idle(2);
      chk_reg("R2 sending", 3'd3, 16'h0002);
      tx_drain(1'b0);
      idle(2);
      chk_reg("R12 tx done pending", 3'd6, 16'h0200);

      // R3 second packet, counter 1
      p = '{16'hA0A0, 16'hB0B0, 16'hC0FF};
      foreach (p[i]) wr(3'd0, p[i]);
      tx_expect(p, 8'h01);
      wr(3'd1, 16'h8000);
      tx_drain(1'b1);

      // R4 full buffer and dropped writes
      net_tx_ready = 1'b0;
      p = {};
      for (int i = 0; i < 16; i++) p.push_back(16'h4000 + 16'(i));
      foreach (p[i]) wr(3'd0, p[i]);
      chk_reg("R4 full", 3'd3, 16'h0005);
      wr(3'd0, 16'hDEAD);
      idle(2);
      chk_reg("R4 overrun error", 3'd3, 16'h000D);
      wr(3'd3, 16'h000D);
      chk_reg("R11 write-back clear", 3'd3, 16'h0005);
      tx_expect(p, 8'h02);
      wr(3'd1, 16'h8000);
      wr(3'd0, 16'hBAD0);
      idle(2);
      chk_reg("R4 write while sending", 3'd3, 16'h000E);
      tx_drain(1'b1);
      idle(2);
      chk_reg("R4 idle after send", 3'd3, 16'h0008);
      wr(3'd3, 16'h0008);

      // R4 flush of an empty buffer
      wr(3'd1, 16'h8000);
      idle(4);
      chk("R4 empty flush", net_tx_valid, 0);
      wr(3'd6, 16'h0600);

      // R5 reception disabled
      p = mkpkt(8'h03, 16'd5, 3, 16'hD001);
      rx_send(p);
      idle(3);
      chk_reg("R5 nothing stored", 3'd3, 16'h0000);
      chk_reg("R6 empty read", 3'd2, 16'h0000);

      // R6 drain with head markers
      wr(3'd1, 16'h1000);
      chk_reg("R5 enable readback", 3'd1, 16'h1000);
      rx_send(p);
      idle(3);
      chk_reg("R6 head first", 3'd3, 16'hA000);
      chk_reg("R12 rx pending", 3'd6, 16'h0400);
      q = p; q.pop_back();
      rx_drain("R6 data", q);
      chk_reg("R6 head last", 3'd3, 16'h9000);
      rx_drain("R6 last word", '{p[p.size()-1]});
      chk_reg("R6 drained", 3'd3, 16'h0000);
      chk_reg("R6 read when empty", 3'd2, 16'h0000);
      chk_reg("R6 still empty", 3'd3, 16'h0000);

      // R7 length mismatch
      rx_send(mkpkt(8'h04, 16'd4, 3, 16'hE000));
      idle(3);
      chk_reg("R7 length error", 3'd3, 16'h0100);
      wr(3'd3, 16'h0100);

      // R9 counter progression (previous stored counter is 3)
      p = mkpkt(8'h05, 16'd0, 0, 16'h0);
      q = mkpkt(8'h05, 16'd1, 1, 16'hF00D);
      rx_send(p);
      idle(3);
      chk_reg("R9 increasing accepted", 3'd3, 16'hA000);
      rx_send(q);
      idle(3);
      chk_reg("R9 repeat counter flagged", 3'd3, 16'hA200);
      rx_drain("R9 first pkt", p);
      rx_drain("R9 flagged pkt still stored", q);
      wr(3'd3, 16'h0200);

      // R8 overflow
      p = mkpkt(8'h06, 16'd40, 20, 16'h6000);
      q = mkpkt(8'h07, 16'd40, 20, 16'h7000);
      rx_send(p);
      rx_send(q);
      idle(3);
      chk_reg("R8 drop flag", 3'd3, 16'hA800);
      rx_drain("R8 earlier pkt intact", p);
      chk_reg("R8 second pkt gone", 3'd3, 16'h0800);
      wr(3'd3, 16'h0800);

      // R10 fault inputs
      flt_rx_timeout = 1; idle(1); flt_rx_timeout = 0;
      flt_store_timeout = 1; idle(1); flt_store_timeout = 0;
      flt_read_timeout = 1; idle(1); flt_read_timeout = 0;
      flt_dist = 1; idle(1); flt_dist = 0;
      flt_fcs = 1; idle(1); flt_fcs = 0;
      chk_reg("R10 fault flags", 3'd3, 16'h04F0);
      wr(3'd3, 16'h0030);
      chk_reg("R11 partial clear", 3'd3, 16'h04C0);
      flt_fcs = 1;
      wr(3'd3, 16'h04C0);
      flt_fcs = 0;
      chk_reg("R11 set wins", 3'd3, 16'h0400);
      wr(3'd3, 16'h0400);
      chk_reg("R11 cleared", 3'd3, 16'h0000);

      // R12 interrupt
      wr(3'd6, 16'h0620);
      chk("R12 tx free irq", irq, 1);
      wr(3'd6, 16'h0100);
      chk("R12 rx avail irq low", irq, 0);
      p = mkpkt(8'h08, 16'd2, 1, 16'h8800);
      rx_send(p);
      idle(2);
      chk("R12 rx avail irq", irq, 1);
      rx_drain("R12 drain", p);
      chk("R12 irq drops when empty", irq, 0);
      wr(3'd6, 16'h0080);
      chk("R12 pending event irq", irq, 1);
      wr(3'd6, 16'h0480);
      chk("R12 pending cleared", irq, 0);
      chk_reg("R12 irq reg", 3'd6, 16'h0080);

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule